// File: doc/BRIEF.md
# Row-Latched Multiplexed-Address DRAM Model

This block is a synthesizable behavioural model of a dynamic memory whose every access goes through a row-wide data latch. A host drives four active-low strobes (row strobe, column strobe, write enable, output enable) and an address bus that carries the row number while the row strobe falls and the column number while the column strobe falls. When the row strobe falls, the chosen row is copied from the storage array into the latch. Each later column strobe either puts one word of that latch on the data output or overwrites one word of it. When the row strobe rises, the whole latch goes back into its row.

The strobes are not treated as true asynchronous edges. Every input goes through a two-stage synchronizer on a fast model clock, and the edges are found there. If several edges land in the same clock they take effect in this order: row fall, column fall, column rise, row rise. A row cycle with no column strobe reloads and restores the row without driving data, so it serves as a refresh. Every row has an age counter that is cleared when the row is written back. A sticky flag is raised when any row goes longer than a retention limit without a write-back. A column strobe that falls while no row is open does nothing except raise a sticky error flag.

Top module: `rowlatch_dram`

## Requirements
- R1: After reset `dout_en`, `dout`, `decay_err` and `strobe_err` are all 0, and every stored word reads back as 0.
- R2: A write cycle stores `din` at the (row, column) given on `addr` at the two strobe falls. A later read cycle to the same location returns that value. Other columns of the row and other rows keep their values.
- R3: `dout_en` is 1 only while a read column access is in progress: it rises after the column strobe falls with `we_n` high and falls after the column strobe rises. It stays 0 for the whole of a write cycle.
- R4: While `oe_n` is high, `dout_en` is 0 even during a read access.
- R5: Several column accesses inside one row cycle (page mode) act on the latch. A word written earlier in the same row cycle reads back at once.
- R6: When the row strobe rises, the latch is written back to the open row, including every word modified in that row cycle, and the row is then closed.
- R7: A row cycle with `cas_n` and `we_n` held high never sets `dout_en` and leaves the row's contents unchanged.
- R8: `decay_err` stays 0 while every row is written back at least once every RETAIN_LIMIT clocks. It becomes 1 and stays 1 once any row goes longer than that.
- R9: A column strobe fall while no row is open changes no stored data and drives no output, and it sets `strobe_err`, which stays 1 until reset.
- R10: `dout` is 0 whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock used to sample the strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled at the column fall |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | DW | Write data |
| dout | output | DW | Read data, 0 when not enabled |
| dout_en | output | 1 | Output driver enable |
| decay_err | output | 1 | Sticky retention violation flag |
| strobe_err | output | 1 | Sticky flag for a column strobe with no open row |

## Verification
The bench uses a page-mode row cycle where a word is written and then read back before the row closes. A model that read from the array instead of the latch would return the old value there. It also checks that the written-back row keeps the untouched neighbouring words, which catches a write-back that dropped or shifted the latch. A column strobe with the row strobe high is followed by a read of the same location, so a model that did not ignore it would show corrupted data or a live output. The bench holds `oe_n` high during a read and also checks `dout_en` during write cycles and refresh cycles, so an output enable that ignored either control would show up. Finally, the bench refreshes every row, waits less than the retention limit, and then waits past it. This exposes a decay flag that fires early, never fires, or is not sticky.

// File: rtl/rld_pkg.sv
package rld_pkg;
    // Kind of column access in progress inside the current row cycle
    typedef enum logic [1:0] {
        COL_NONE  = 2'd0,
        COL_READ  = 2'd1,
        COL_WRITE = 2'd2
    } col_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/rld_sync.sv
module rld_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '1;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '1;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/rld_store.sv
module rld_store #(
    parameter int unsigned ROW_AW       = 3,
    parameter int unsigned ROW_W        = 64,
    parameter int unsigned RETAIN_LIMIT = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_AW-1:0] rd_row,
    output logic [ROW_W-1:0]  rd_data,
    input  logic              wb_en,
    input  logic [ROW_AW-1:0] wb_row,
    input  logic [ROW_W-1:0]  wb_data,
    output logic              decay_err
);
    localparam int unsigned ROWS  = 1 << ROW_AW;
    localparam int unsigned AGE_W = $clog2(RETAIN_LIMIT + 2);

    logic [ROW_W-1:0] cells     [ROWS];
    logic [ROWS-1:0]  overdue;
    logic             decay_d, decay_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [ROW_W-1:0] cell_d, cell_q;
        logic [AGE_W-1:0] age_d,  age_q;
        logic             hit;

        always_comb begin
            hit    = wb_en && (wb_row == ROW_AW'(r));
            cell_d = cell_q;
            age_d  = age_q;
            if (hit) begin
                cell_d = wb_data;
                age_d  = '0;
            end else if (age_q <= AGE_W'(RETAIN_LIMIT)) begin
                age_d  = age_q + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
                age_q  <= '0;
            end else begin
                cell_q <= cell_d;
                age_q  <= age_d;
            end
        end

        assign cells[r]   = cell_q;
        assign overdue[r] = (age_q > AGE_W'(RETAIN_LIMIT));
    end

    assign rd_data = cells[rd_row];

    always_comb decay_d = decay_q | (|overdue);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) decay_q <= 1'b0;
        else        decay_q <= decay_d;
    end

    assign decay_err = decay_q;
endmodule

// File: rtl/rld_ctrl.sv
module rld_ctrl
    import rld_pkg::*;
#(
    parameter int unsigned ROW_AW = 3,
    parameter int unsigned COL_AW = 3,
    parameter int unsigned DW     = 8,
    parameter int unsigned AW     = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ras_s,
    input  logic                     cas_s,
    input  logic                     we_s,
    input  logic                     oe_s,
    input  logic [AW-1:0]            addr_s,
    input  logic [DW-1:0]            din_s,
    output logic [ROW_AW-1:0]        rd_row,
    input  logic [(DW<<COL_AW)-1:0]  rd_data,
    output logic                     wb_en,
    output logic [ROW_AW-1:0]        wb_row,
    output logic [(DW<<COL_AW)-1:0]  wb_data,
    output logic [DW-1:0]            dout,
    output logic                     dout_en,
    output logic                     strobe_err,
    output logic                     row_open,
    output logic                     cas_prev
);
    localparam int unsigned ROW_W = DW << COL_AW;

    typedef struct packed {
        logic              ras_prev;
        logic              cas_prev;
        logic              open;
        logic [ROW_AW-1:0] row;
        logic [COL_AW-1:0] col;
        col_e              cmode;
        logic              serr;
        logic [ROW_W-1:0]  latch;
    } st_t;

    st_t  st_d, st_q;
    logic ras_fall, ras_rise, cas_fall, cas_rise;

    assign rd_row = addr_s[ROW_AW-1:0];

    always_comb begin
        st_d     = st_q;
        wb_en    = 1'b0;
        wb_row   = st_q.row;
        wb_data  = st_q.latch;

        ras_fall = st_q.ras_prev & ~ras_s;
        ras_rise = ~st_q.ras_prev & ras_s;
        cas_fall = st_q.cas_prev & ~cas_s;
        cas_rise = ~st_q.cas_prev & cas_s;

        st_d.ras_prev = ras_s;
        st_d.cas_prev = cas_s;

        // 1: row strobe fall opens the row and fills the latch
        if (ras_fall) begin
            st_d.open  = 1'b1;
            st_d.row   = addr_s[ROW_AW-1:0];
            st_d.latch = rd_data;
        end

        // 2: column strobe fall selects a word of the latch
        if (cas_fall) begin
            if (st_d.open) begin
                st_d.col = addr_s[COL_AW-1:0];
                if (!we_s) begin
                    st_d.latch[addr_s[COL_AW-1:0]*DW +: DW] = din_s;
                    st_d.cmode = COL_WRITE;
                end else begin
                    st_d.cmode = COL_READ;
                end
            end else begin
                st_d.serr = 1'b1;
            end
        end

        // 3: column strobe rise ends the column access
        if (cas_rise) begin
            st_d.cmode = COL_NONE;
        end

        // 4: row strobe rise restores the latch into the row
        if (ras_rise && st_d.open) begin
            wb_en     = 1'b1;
            wb_row    = st_d.row;
            wb_data   = st_d.latch;
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ras_prev <= 1'b1;
            st_q.cas_prev <= 1'b1;
            st_q.cmode    <= COL_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_en    = (st_q.cmode == COL_READ) && !oe_s;
    assign dout       = dout_en ? st_q.latch[st_q.col*DW +: DW] : '0;
    assign strobe_err = st_q.serr;
    assign row_open   = st_q.open;
    assign cas_prev   = st_q.cas_prev;
endmodule

// File: rtl/rowlatch_dram.sv
module rowlatch_dram
    import rld_pkg::*;
#(
    parameter int unsigned ROW_AW       = 3,
    parameter int unsigned COL_AW       = 3,
    parameter int unsigned DW           = 8,
    parameter int unsigned RETAIN_LIMIT = 4000,
    parameter int unsigned SYNC_STAGES  = 2,
    localparam int unsigned AW          = max_u(ROW_AW, COL_AW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          decay_err,
    output logic          strobe_err
);
    localparam int unsigned ROW_W  = DW << COL_AW;
    localparam int unsigned SYNC_W = 4 + AW + DW;

    logic [SYNC_W-1:0] raw_in, synced;
    logic              ras_s, cas_s, we_s, oe_s;
    logic [AW-1:0]     addr_s;
    logic [DW-1:0]     din_s;
    logic [ROW_AW-1:0] rd_row, wb_row;
    logic [ROW_W-1:0]  rd_data, wb_data;
    logic              wb_en, row_open, cas_prev;

    assign raw_in = {ras_n, cas_n, we_n, oe_n, addr, din};

    rld_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(synced)
    );

    assign {ras_s, cas_s, we_s, oe_s, addr_s, din_s} = synced;

    rld_ctrl #(.ROW_AW(ROW_AW), .COL_AW(COL_AW), .DW(DW), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ras_s(ras_s), .cas_s(cas_s), .we_s(we_s), .oe_s(oe_s),
        .addr_s(addr_s), .din_s(din_s),
        .rd_row(rd_row), .rd_data(rd_data),
        .wb_en(wb_en), .wb_row(wb_row), .wb_data(wb_data),
        .dout(dout), .dout_en(dout_en), .strobe_err(strobe_err),
        .row_open(row_open), .cas_prev(cas_prev)
    );

    rld_store #(.ROW_AW(ROW_AW), .ROW_W(ROW_W), .RETAIN_LIMIT(RETAIN_LIMIT)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_row(rd_row), .rd_data(rd_data),
        .wb_en(wb_en), .wb_row(wb_row), .wb_data(wb_data),
        .decay_err(decay_err)
    );
endmodule

// File: rtl/rld_checker.sv
module rld_checker #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic          strobe_err,
    input logic          decay_err,
    input logic          wb_en,
    input logic          row_open,
    input logic          cas_prev
);
    assert_out_needs_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !cas_prev);

    assert_wb_needs_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> row_open);

    assert_wb_closes_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> !row_open);

    assert_decay_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        decay_err |=> decay_err);

    assert_strobe_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_err |=> strobe_err);

    // R10: output bus idle whenever not driven
    always @(negedge clk) begin
        if (rst_n) assert_idle_bus_R10: assert (dout_en || dout == '0);
    end
endmodule

bind rowlatch_dram rld_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dout(dout), .dout_en(dout_en),
    .strobe_err(strobe_err), .decay_err(decay_err), .wb_en(wb_en),
    .row_open(row_open), .cas_prev(cas_prev)
);

// File: tb/rowlatch_dram_test.sv
`timescale 1ns/1ps
module rowlatch_dram_test;
    localparam int unsigned RA     = 3;
    localparam int unsigned CA     = 3;
    localparam int unsigned DW     = 8;
    localparam int unsigned RETAIN = 3000;
    localparam int unsigned AW     = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en, decay_err, strobe_err;

    int unsigned nchk = 0, nfail = 0;
    logic [DW-1:0] mdl [8][8];

    always #2 clk = ~clk;

    rowlatch_dram #(.ROW_AW(RA), .COL_AW(CA), .DW(DW), .RETAIN_LIMIT(RETAIN)) uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .decay_err(decay_err), .strobe_err(strobe_err)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic row_down(input int r);
        addr = AW'(r); ras_n = 1'b0; step(4);
    endtask

    task automatic row_up();
        ras_n = 1'b1; step(4);
    endtask

    task automatic col_write(input int r, input int c, input logic [DW-1:0] d);
        addr = AW'(c); din = d; we_n = 1'b0; cas_n = 1'b0; step(4);
        chk("R3 no drive during write", {31'd0, dout_en}, 32'd0);
        cas_n = 1'b1; we_n = 1'b1; step(4);
        mdl[r][c] = d;
    endtask

    task automatic col_read(input int c, input logic [DW-1:0] exp, input string tag);
        addr = AW'(c); cas_n = 1'b0; step(4);
        chk({tag, " read enable"}, {31'd0, dout_en}, 32'd1);
        chk({tag, " read data"}, {24'd0, dout}, {24'd0, exp});
        cas_n = 1'b1; step(4);
        chk("R3 enable off after column rise", {31'd0, dout_en}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 dout_en after reset", {31'd0, dout_en}, 32'd0);
        chk("R1 dout after reset", {24'd0, dout}, 32'd0);
        chk("R1 decay_err after reset", {31'd0, decay_err}, 32'd0);
        chk("R1 strobe_err after reset", {31'd0, strobe_err}, 32'd0);
        row_down(6); col_read(4, 8'h00, "R1"); row_up();
    endtask

    task automatic t_write_read();
        row_down(1); col_write(1, 2, 8'hA5); row_up();
        row_down(2); col_write(2, 2, 8'h3C); row_up();
        row_down(1); col_read(2, mdl[1][2], "R2"); col_read(3, mdl[1][3], "R2 neighbour"); row_up();
        row_down(2); col_read(2, mdl[2][2], "R2 other row"); row_up();
    endtask

    task automatic t_oe_high();
        row_down(1); oe_n = 1'b1; addr = AW'(2); cas_n = 1'b0; step(4);
        chk("R4 enable with oe high", {31'd0, dout_en}, 32'd0);
        chk("R10 dout idle with oe high", {24'd0, dout}, 32'd0);
        oe_n = 1'b0; step(4);
        chk("R4 enable once oe low", {31'd0, dout_en}, 32'd1);
        cas_n = 1'b1; step(4); row_up();
    endtask

    task automatic t_page();
        row_down(5);
        col_write(5, 0, 8'h11);
        col_write(5, 7, 8'hE7);
        col_read(0, 8'h11, "R5 page");
        col_write(5, 0, 8'h22);
        col_read(0, 8'h22, "R5 page rewrite");
        col_read(7, 8'hE7, "R5 page");
        row_up();
        row_down(5);
        col_read(0, mdl[5][0], "R6 writeback");
        col_read(7, mdl[5][7], "R6 writeback");
        col_read(3, mdl[5][3], "R6 untouched word");
        row_up();
    endtask

    task automatic t_refresh();
        row_down(1); step(6);
        chk("R7 no output in refresh", {31'd0, dout_en}, 32'd0);
        row_up();
        chk("R7 no output after refresh", {31'd0, dout_en}, 32'd0);
        row_down(1); col_read(2, mdl[1][2], "R7 data kept"); row_up();
    endtask

    task automatic t_cas_no_row();
        addr = AW'(2); din = 8'hEE; we_n = 1'b0; cas_n = 1'b0; step(4);
        chk("R9 strobe_err set", {31'd0, strobe_err}, 32'd1);
        chk("R9 no drive", {31'd0, dout_en}, 32'd0);
        cas_n = 1'b1; we_n = 1'b1; step(4);
        oe_n = 1'b0; cas_n = 1'b0; step(4);
        chk("R9 no drive on read without row", {31'd0, dout_en}, 32'd0);
        cas_n = 1'b1; step(4);
        row_down(2); col_read(2, mdl[2][2], "R9 data unchanged"); row_up();
        chk("R9 strobe_err sticky", {31'd0, strobe_err}, 32'd1);
    endtask

    task automatic t_decay();
        for (int r = 0; r < 8; r++) begin
            row_down(r); row_up();
        end
        step(RETAIN / 2);
        chk("R8 decay clear when refreshed", {31'd0, decay_err}, 32'd0);
        step(RETAIN + 100);
        chk("R8 decay set after limit", {31'd0, decay_err}, 32'd1);
        step(50);
        chk("R8 decay sticky", {31'd0, decay_err}, 32'd1);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) mdl[r][c] = '0;
        step(3); rst_n = 1'b1; step(3);
        t_reset();
        t_write_read();
        t_oe_high();
        t_page();
        t_refresh();
        t_cas_no_row();
        t_decay();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule